// File: doc/BRIEF.md
# Precise Exception Commit Arbiter

This block sits at the retirement end of a pipelined core. Each cycle it sees a group of instruction slots in program order, with slot 0 the oldest. Each slot carries a valid bit, its PC, a flag marking it as squashed speculative work, and an event class. The block also sees an external interrupt request with an enable and an acknowledge. From these inputs it decides which slots retire and whether an event is taken. When an event is taken, it records the resume address and a cause code, and it asks the front end to flush and redirect to the handler.

The resume address depends on the kind of event. Instructions are 4 bytes long. An instruction that must be retried saves its own address. A deliberate call saves the following address. An interrupt saves the address of the oldest live instruction, which has not yet committed. An unrecoverable abort saves no address and instead pulses a kill output. An interrupt that loses to a synchronous event is held in a sticky pending bit until it is taken or acknowledged.

Top module: `exc_commit_arb`

## Requirements
- R1: While reset is asserted and on the first cycle after it, flush_o, redirect_valid_o and kill_o are 0, cause_o is 0, epc_o is 0 and no interrupt is pending.
- R2: Event class 1 (fault) on the selected slot gives cause 1 and epc equal to that slot's PC, and that slot does not commit.
- R3: Event class 2 (trap) on the selected slot gives cause 2 and epc equal to its PC plus 4, and that slot commits.
- R4: Event class 3 (abort) gives cause 3 and a kill_o pulse, leaves epc_o unchanged, and the slot does not commit.
- R5: Event class 4 (divide-by-zero) gives cause 4 and epc equal to the slot's own PC, and the slot does not commit.
- R6: When several live slots carry events, only the lowest-index slot (the oldest) is reported, and every younger slot's commit is suppressed.
- R7: A slot that is invalid or squashed never commits and its event is ignored. A younger live slot's event is then the one reported.
- R8: An interrupt request (irq_i or the pending bit) with irq_en_i high, in a cycle with no synchronous event and at least one live slot, is taken with cause 5. Its epc is the PC of the oldest live slot, and no slot commits.
- R9: When a synchronous event and an interrupt request coincide, the synchronous event is taken and the interrupt stays pending for a later cycle.
- R10: The pending bit is set by irq_i and is cleared only when the interrupt is taken or irq_ack_i is high.
- R11: flush_o and redirect_valid_o are high for exactly the cycle after each decision cycle that took an event. epc_o and cause_o change only on such cycles.
- R12: A live slot with no event (class 0, or a class code of 5 to 7) commits in the same cycle when no older slot took an event and no interrupt is taken. The commit_o output is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slot_valid_i | input | NSLOT | Slot holds an instruction |
| slot_pc_i | input | NSLOT*XLEN | Slot PCs, slot i at bits [i*XLEN +: XLEN] |
| slot_squash_i | input | NSLOT | Slot is squashed speculative work |
| slot_evt_i | input | NSLOT*3 | Slot event class, slot i at bits [i*3 +: 3] |
| irq_i | input | 1 | External interrupt request |
| irq_en_i | input | 1 | Interrupt enable (mask) |
| irq_ack_i | input | 1 | Clears a pending interrupt |
| commit_o | output | NSLOT | Per-slot commit this cycle |
| flush_o | output | 1 | Pipeline flush pulse |
| redirect_valid_o | output | 1 | Handler redirect valid |
| kill_o | output | 1 | Terminate process (abort) |
| cause_o | output | 3 | Last taken cause code |
| epc_o | output | XLEN | Last saved resume address |

## Verification
The bench targets the cases where a plausible mistake changes the resume address. A trap that saves its own PC would loop on the system call forever. A fault that saves PC plus 4 would skip the failing load. An abort that overwrites epc would corrupt the saved state. It drives a squashed older fault next to a live younger trap, so a design that forgets the squash flag reports the wrong slot. It also drives a fault in the same cycle as an interrupt, so a design that drops the loser loses the interrupt, and one that lets the interrupt win takes it too early. An acknowledge with the interrupt masked checks that the pending bit really clears, and random traffic compares every cycle against a reference model.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CAUSE_W = 3;
  localparam int INSN_BYTES = 4;

  typedef enum logic [CAUSE_W-1:0] {
    CS_NONE  = 3'd0,
    CS_FAULT = 3'd1,
    CS_TRAP  = 3'd2,
    CS_ABORT = 3'd3,
    CS_DIV0  = 3'd4,
    CS_IRQ   = 3'd5
  } exc_cause_e;
endpackage

// File: rtl/exc_slot_qual.sv
module exc_slot_qual
  import exc_pkg::*;
(
  input  logic               valid_i,
  input  logic               squash_i,
  input  logic [CAUSE_W-1:0] evt_i,
  output logic               live_o,
  output logic               has_evt_o,
  output logic               retires_o,
  output exc_cause_e         evt_o
);
  always_comb begin
    live_o = valid_i & ~squash_i;
    unique case (evt_i)
      3'd1:    evt_o = CS_FAULT;
      3'd2:    evt_o = CS_TRAP;
      3'd3:    evt_o = CS_ABORT;
      3'd4:    evt_o = CS_DIV0;
      default: evt_o = CS_NONE; // undefined classes behave as plain instructions
    endcase
    has_evt_o = live_o && (evt_o != CS_NONE);
    // a trap has done its work and retires; the other events do not
    retires_o = live_o && (evt_o == CS_NONE || evt_o == CS_TRAP);
  end
endmodule

// File: rtl/exc_pick.sv
module exc_pick #(
  parameter int NSLOT = 2,
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic [NSLOT-1:0] live_i,
  input  logic [NSLOT-1:0] has_evt_i,
  output logic             evt_found_o,
  output logic [IDX_W-1:0] evt_idx_o,
  output logic             live_found_o,
  output logic [IDX_W-1:0] live_idx_o,
  output logic [NSLOT-1:0] not_younger_o
);
  always_comb begin
    evt_found_o   = 1'b0;
    evt_idx_o     = '0;
    live_found_o  = 1'b0;
    live_idx_o    = '0;
    not_younger_o = '0;
    for (int i = 0; i < NSLOT; i++) begin
      // slot i is not younger than an event slot when none was found before it
      not_younger_o[i] = ~evt_found_o;
      if (has_evt_i[i] && !evt_found_o) begin
        evt_found_o = 1'b1;
        evt_idx_o   = IDX_W'(i);
      end
      if (live_i[i] && !live_found_o) begin
        live_found_o = 1'b1;
        live_idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/exc_irq_pend.sv
module exc_irq_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic ack_i,
  input  logic take_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= 1'b0;
    else         pend_o <= (pend_o | irq_i) & ~(take_i | ack_i);
  end
endmodule

// File: rtl/exc_commit_arb.sv
module exc_commit_arb
  import exc_pkg::*;
#(
  parameter int NSLOT = 2,
  parameter int XLEN  = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NSLOT-1:0]         slot_valid_i,
  input  logic [NSLOT*XLEN-1:0]    slot_pc_i,
  input  logic [NSLOT-1:0]         slot_squash_i,
  input  logic [NSLOT*CAUSE_W-1:0] slot_evt_i,
  input  logic                     irq_i,
  input  logic                     irq_en_i,
  input  logic                     irq_ack_i,
  output logic [NSLOT-1:0]         commit_o,
  output logic                     flush_o,
  output logic                     redirect_valid_o,
  output logic                     kill_o,
  output logic [CAUSE_W-1:0]       cause_o,
  output logic [XLEN-1:0]          epc_o
);
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [NSLOT-1:0] live, has_evt, retires, not_younger;
  exc_cause_e       evt [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    exc_slot_qual u_qual (
      .valid_i   (slot_valid_i[g]),
      .squash_i  (slot_squash_i[g]),
      .evt_i     (slot_evt_i[g*CAUSE_W +: CAUSE_W]),
      .live_o    (live[g]),
      .has_evt_o (has_evt[g]),
      .retires_o (retires[g]),
      .evt_o     (evt[g])
    );
  end

  logic             evt_found, live_found;
  logic [IDX_W-1:0] evt_idx, live_idx;

  exc_pick #(.NSLOT(NSLOT)) u_pick (
    .live_i        (live),
    .has_evt_i     (has_evt),
    .evt_found_o   (evt_found),
    .evt_idx_o     (evt_idx),
    .live_found_o  (live_found),
    .live_idx_o    (live_idx),
    .not_younger_o (not_younger)
  );

  logic irq_pend, irq_req, irq_take;

  // synchronous events win; the interrupt needs a live slot to resume at
  assign irq_req  = (irq_i | irq_pend) & irq_en_i;
  assign irq_take = irq_req & ~evt_found & live_found;

  exc_irq_pend u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .ack_i  (irq_ack_i),
    .take_i (irq_take),
    .pend_o (irq_pend)
  );

  assign commit_o = retires & not_younger & {NSLOT{~irq_take}};

  exc_cause_e       sel_evt;
  logic [XLEN-1:0]  sel_pc, live_pc;
  logic             take;
  exc_cause_e       cause_d;
  logic [XLEN-1:0]  epc_d;

  always_comb begin
    sel_evt = evt[evt_idx];
    sel_pc  = slot_pc_i[evt_idx*XLEN +: XLEN];
    live_pc = slot_pc_i[live_idx*XLEN +: XLEN];
    take    = evt_found | irq_take;
    cause_d = exc_cause_e'(cause_o);
    epc_d   = epc_o;
    if (evt_found) begin
      cause_d = sel_evt;
      unique case (sel_evt)
        CS_TRAP:  epc_d = sel_pc + XLEN'(INSN_BYTES);
        CS_ABORT: epc_d = epc_o;
        default:  epc_d = sel_pc;
      endcase
    end else if (irq_take) begin
      cause_d = CS_IRQ;
      epc_d   = live_pc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_o          <= 1'b0;
      redirect_valid_o <= 1'b0;
      kill_o           <= 1'b0;
      cause_o          <= '0;
      epc_o            <= '0;
    end else begin
      flush_o          <= take;
      redirect_valid_o <= take;
      kill_o           <= evt_found && (sel_evt == CS_ABORT);
      if (take) begin
        cause_o <= cause_d;
        epc_o   <= epc_d;
      end
    end
  end
endmodule

// File: rtl/exc_commit_arb_chk.sv
module exc_commit_arb_chk #(
  parameter int NSLOT = 2,
  parameter int XLEN  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NSLOT-1:0] slot_valid_i,
  input logic [NSLOT-1:0] slot_squash_i,
  input logic             irq_en_i,
  input logic [NSLOT-1:0] commit_o,
  input logic             flush_o,
  input logic             redirect_valid_o,
  input logic             kill_o,
  input logic [2:0]       cause_o,
  input logic [XLEN-1:0]  epc_o
);
  // R11: flush and redirect travel together
  a_r11_flush_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o == redirect_valid_o);

  // R11: saved state moves only on a taken event
  a_r11_epc_only_on_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(epc_o) |-> flush_o);

  a_r11_cause_only_on_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cause_o) |-> flush_o);

  // R4: kill comes only with an abort cause and a flush
  a_r4_kill_is_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_o |-> (flush_o && cause_o == 3'd3));

  // R4: an abort keeps the previous return address
  a_r4_abort_keeps_epc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_o |-> $stable(epc_o));

  // R7: squashed or invalid slots never commit
  a_r7_no_dead_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o & ~(slot_valid_i & ~slot_squash_i)) == '0);

  // R8: a taken interrupt had its enable high in the deciding cycle
  a_r8_irq_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && cause_o == 3'd5) |-> $past(irq_en_i));

  // R12 / R6: a younger slot commits only behind a committed or dead older slot
  for (genvar i = 1; i < NSLOT; i++) begin : g_order
    a_r12_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit_o[i] |-> (commit_o[i-1] || !(slot_valid_i[i-1] && !slot_squash_i[i-1])));
  end
endmodule

bind exc_commit_arb exc_commit_arb_chk #(.NSLOT(NSLOT), .XLEN(XLEN)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .slot_valid_i     (slot_valid_i),
  .slot_squash_i    (slot_squash_i),
  .irq_en_i         (irq_en_i),
  .commit_o         (commit_o),
  .flush_o          (flush_o),
  .redirect_valid_o (redirect_valid_o),
  .kill_o           (kill_o),
  .cause_o          (cause_o),
  .epc_o            (epc_o)
);

// File: tb/exc_commit_arb_bench.sv
module exc_commit_arb_bench;
  localparam int NSLOT = 2;
  localparam int XLEN  = 32;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [NSLOT-1:0]     slot_valid_i = '0;
  logic [NSLOT*XLEN-1:0] slot_pc_i = '0;
  logic [NSLOT-1:0]     slot_squash_i = '0;
  logic [NSLOT*3-1:0]   slot_evt_i = '0;
  logic                 irq_i = 1'b0, irq_en_i = 1'b0, irq_ack_i = 1'b0;
  logic [NSLOT-1:0]     commit_o;
  logic                 flush_o, redirect_valid_o, kill_o;
  logic [2:0]           cause_o;
  logic [XLEN-1:0]      epc_o;

  always #4 clk_i = ~clk_i;

  exc_commit_arb #(.NSLOT(NSLOT), .XLEN(XLEN)) u_exc_commit_arb (.*);

  int checks = 0, errors = 0;
  logic            m_pend = 1'b0;
  logic [2:0]      m_cause = '0;
  logic [XLEN-1:0] m_epc = '0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string cause_tag(logic [2:0] c);
    case (c)
      3'd1: return "R2"; 3'd2: return "R3"; 3'd3: return "R4";
      3'd4: return "R5"; 3'd5: return "R8"; default: return "R11";
    endcase
  endfunction

  task automatic drive(logic [1:0] v, logic [1:0] sq, logic [2:0] e0, logic [2:0] e1,
                       logic [XLEN-1:0] pc0, logic [XLEN-1:0] pc1,
                       logic irq, logic en, logic ack);
    slot_valid_i = v; slot_squash_i = sq; slot_evt_i = {e1, e0};
    slot_pc_i = {pc1, pc0}; irq_i = irq; irq_en_i = en; irq_ack_i = ack;
  endtask

  // model one decision cycle and compare
  task automatic step(string tag);
    int e = -1, fl = -1;
    logic [NSLOT-1:0] exp_commit = '0;
    logic itake, take, kill;
    logic [2:0] ev;
    for (int i = 0; i < NSLOT; i++) begin
      logic lv = slot_valid_i[i] & ~slot_squash_i[i];
      logic [2:0] c = slot_evt_i[i*3 +: 3];
      if (lv && fl < 0) fl = i;
      if (lv && c >= 3'd1 && c <= 3'd4 && e < 0) e = i;
    end
    itake = (e < 0) && ((irq_i | m_pend) & irq_en_i) && (fl >= 0);
    for (int i = 0; i < NSLOT; i++) begin
      logic lv = slot_valid_i[i] & ~slot_squash_i[i];
      logic [2:0] c = slot_evt_i[i*3 +: 3];
      logic plain = !(c >= 3'd1 && c <= 3'd4);
      exp_commit[i] = lv && !itake && (e < 0 || i < e || (i == e && c == 3'd2)) && (plain || c == 3'd2);
    end
    #1;
    chk({tag, "/R12"}, "commit_o", 64'(commit_o), 64'(exp_commit));
    take = (e >= 0) || itake;
    kill = 1'b0;
    if (e >= 0) begin
      ev = slot_evt_i[e*3 +: 3];
      m_cause = ev;
      if (ev == 3'd2) m_epc = slot_pc_i[e*XLEN +: XLEN] + 4;
      else if (ev == 3'd3) kill = 1'b1;
      else m_epc = slot_pc_i[e*XLEN +: XLEN];
    end else if (itake) begin
      m_cause = 3'd5;
      m_epc = slot_pc_i[fl*XLEN +: XLEN];
    end
    m_pend = (m_pend | irq_i) & ~(itake | irq_ack_i);
    @(posedge clk_i);
    @(negedge clk_i);
    chk({tag, "/", cause_tag(take ? m_cause : 3'd0)}, "flush_o", 64'(flush_o), 64'(take));
    chk({tag, "/R11"}, "redirect_valid_o", 64'(redirect_valid_o), 64'(take));
    chk({tag, "/R4"}, "kill_o", 64'(kill_o), 64'(kill));
    chk({tag, "/", cause_tag(m_cause)}, "cause_o", 64'(cause_o), 64'(m_cause));
    chk({tag, "/", cause_tag(m_cause)}, "epc_o", 64'(epc_o), 64'(m_epc));
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", "flush_o", 64'(flush_o), 64'd0);
    chk("R1", "kill_o", 64'(kill_o), 64'd0);
    chk("R1", "cause_o", 64'(cause_o), 64'd0);
    chk("R1", "epc_o", 64'(epc_o), 64'd0);
    rst_ni = 1'b1;
    drive(2'b00, 2'b00, 0, 0, 0, 0, 0, 1, 0);
    step("R1");

    drive(2'b11, 2'b00, 3'd1, 3'd0, 32'h100, 32'h104, 0, 1, 0); step("R2");   // fault retries itself
    drive(2'b11, 2'b00, 3'd0, 3'd2, 32'h200, 32'h204, 0, 1, 0); step("R3");   // trap resumes after
    drive(2'b01, 2'b00, 3'd3, 3'd0, 32'h300, 32'h304, 0, 1, 0); step("R4");   // abort keeps epc
    drive(2'b11, 2'b00, 3'd4, 3'd0, 32'h400, 32'h404, 0, 1, 0); step("R5");   // divide-by-zero
    drive(2'b11, 2'b00, 3'd1, 3'd2, 32'h500, 32'h504, 0, 1, 0); step("R6");   // oldest wins
    drive(2'b11, 2'b01, 3'd1, 3'd2, 32'h600, 32'h604, 0, 1, 0); step("R7");   // squashed fault dropped
    drive(2'b11, 2'b00, 3'd0, 3'd0, 32'h700, 32'h704, 1, 1, 0); step("R8");   // interrupt taken
    // R9: fault beats interrupt, interrupt survives idle cycle, then is taken
    drive(2'b01, 2'b00, 3'd1, 3'd0, 32'h800, 32'h804, 1, 1, 0); step("R9");
    drive(2'b00, 2'b00, 3'd0, 3'd0, 32'h0, 32'h0, 0, 1, 0);     step("R9");
    drive(2'b10, 2'b00, 3'd0, 3'd0, 32'h900, 32'h904, 0, 1, 0); step("R9");
    chk("R9", "cause_o", 64'(cause_o), 64'd5);
    chk("R9", "epc_o", 64'(epc_o), 64'h904);
    // R10: masked request, acknowledged, then enabled: nothing taken
    drive(2'b00, 2'b00, 0, 0, 0, 0, 1, 0, 0);                   step("R10");
    drive(2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 1);                   step("R10");
    drive(2'b01, 2'b00, 3'd0, 3'd0, 32'hA00, 32'hA04, 0, 1, 0); step("R10");
    chk("R10", "flush_o", 64'(flush_o), 64'd0);
    drive(2'b11, 2'b00, 3'd0, 3'd0, 32'hB00, 32'hB04, 0, 1, 0); step("R11");  // quiet cycle
    drive(2'b11, 2'b00, 3'd6, 3'd7, 32'hC00, 32'hC04, 0, 1, 0); step("R12");  // undefined classes commit

    for (int n = 0; n < 3000; n++) begin
      logic [2:0] e0 = 3'($urandom_range(0, 5));
      logic [2:0] e1 = 3'($urandom_range(0, 5));
      drive(2'($urandom), 2'($urandom_range(0, 3) == 0 ? $urandom : 0), e0, e1,
            {$urandom_range(0, 4095), 2'b00}, {$urandom_range(0, 4095), 2'b00},
            $urandom_range(0, 7) == 0, $urandom_range(0, 3) != 0, $urandom_range(0, 15) == 0);
      step("RND");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule